// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 64-byte type 0 configuration header of a bus target. A configuration access arrives as a dword index, four byte enables and write data. Reads return a registered dword one cycle later. Writes update the writable fields byte by byte. The bus protocol engine sits outside the block and issues these accesses. The address decoder reads the command bits and the base addresses directly from the ports.

The block holds up to three base address registers. Each one is set by parameter as either a memory window or an I/O window, with a size from 16 bytes to 2 GB. Address bits below the window size read as zero. Software can therefore write all ones and read the value back to learn the size.

Identification, class, header type, subsystem, capability pointer and interrupt pin/grant/latency values are fixed parameters. Dwords with an index of 16 or more (byte offsets 40h–FFh) do not touch internal state. They are sent to a user extension port, and its read data is returned unchanged.

Top module: `cfghdr_regs`

## Requirements
- R1: Dwords 0 (device/vendor ID), 2 (class/revision), 11 (subsystem IDs) and 13 (capability pointer in byte 0) read their parameter values, and writes to them change nothing.
- R2: Dwords 7–10, 12 and 14, and the slot of any BAR at or above NUM_BARS, read as zero.
- R3: A read accepted on one rising edge gives rd_valid high with its data after that edge. rd_valid is low after any edge without a read; writes never raise it.
- R4: The command half (dword 1, bits 15:0) stores only bit 0 (I/O enable), bit 1 (memory enable), bit 2 (bus master), bit 6 (parity response), bit 8 (system error enable) and bit 10 (interrupt disable). All other command bits read zero. The six command output ports always show the stored bits.
- R5: In status (dword 1, bits 31:16), err_evt[0] sets status bit 8 and err_evt[5:1] set status bits 15:11. Writing a one clears such a bit, and writing zero leaves it. An event in the same cycle as a clear leaves the bit set. Status bit 9 reads 1, bit 4 reads 1 when the capability pointer is non-zero, and bit 5 reads the FAST66 parameter.
- R6: For a BAR of size 2^S bytes, bits S-1:0 of the stored address are always zero. After an all-ones write, a read returns the size mask.
- R7: BAR bit 0 reads 1 for an I/O window and 0 for a memory window.
- R8: Writes obey each byte enable separately: cache line size (dword 3 byte 0), latency timer (dword 3 byte 1), interrupt line (dword 15 byte 0) and BAR bytes.
- R9: An access with index ≥ 16 drives ext_sel in the same cycle, and ext_wr as well for a write. Its read returns ext_rdata. It leaves all internal registers unchanged.
- R10: Reset clears command, status, the BARs, cache line size, latency timer, interrupt line and rd_valid.
- R11: bar_base presents each stored BAR address, 32 bits per slot, with BAR n in bits 32n+31:32n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Configuration access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_index | input | 6 | Dword index (byte offset / 4) |
| acc_be | input | 4 | Byte enables of the write |
| acc_wdata | input | 32 | Write data |
| err_evt | input | 6 | Error events that set status bits |
| ext_rdata | input | 32 | Read data from the user extension |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Registered read data |
| ext_sel | output | 1 | Access targets the extension area |
| ext_wr | output | 1 | Extension access is a write |
| cmd_io_en | output | 1 | Command bit 0 |
| cmd_mem_en | output | 1 | Command bit 1 |
| cmd_bus_master | output | 1 | Command bit 2 |
| cmd_perr_resp | output | 1 | Command bit 6 |
| cmd_serr_en | output | 1 | Command bit 8 |
| cmd_int_dis | output | 1 | Command bit 10 |
| bar_base | output | 96 | Stored BAR addresses, 32 bits per slot |

## Verification
The bench builds the block with all three BAR slots enabled. BAR0 is a 4 KB memory window, BAR1 is a 16-byte I/O window and BAR2 is a 2 GB memory window. This covers both window types and both size extremes, where only bit 31, or bits 31:4, can be stored. The capability pointer is non-zero and FAST66 is set, so every read-only status bit is visible. Random accesses with random byte enables and error events cover the whole index range, including the extension area. This brings the event-versus-clear collision and partial-byte BAR writes within reach.

// File: rtl/cfghdr_pkg.sv
package cfghdr_pkg;
  localparam int DW        = 32;
  localparam int BE_W      = DW / 8;
  localparam int IDX_W     = 6;
  localparam int MAX_BARS  = 3;
  localparam int SZ_W      = 5;
  localparam int EXT_FIRST = 16;
  localparam int BAR_FIRST = 4;

  localparam logic [15:0] CMD_RW_MASK = 16'h0547;
  localparam logic [15:0] STS_W1C_MASK = 16'hF900;

  function automatic logic [DW-1:0] be_merge(input logic [DW-1:0] old_v,
                                             input logic [DW-1:0] new_v,
                                             input logic [BE_W-1:0] be);
    logic [DW-1:0] r;
    r = old_v;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cfghdr_bar.sv
module cfghdr_bar
  import cfghdr_pkg::*;
#(
  parameter bit IS_IO   = 1'b0,
  parameter int SZ_LOG2 = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [BE_W-1:0] be,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rd_val,
  output logic [DW-1:0]   base
);
  localparam logic [DW-1:0] ADDR_MASK = {DW{1'b1}} << SZ_LOG2;

  logic [DW-1:0] bar_q;

  always_ff @(posedge clk) begin
    if (rst)        bar_q <= '0;
    else if (wr_en) bar_q <= be_merge(bar_q, wdata, be) & ADDR_MASK;
  end

  assign rd_val = bar_q | {{(DW-1){1'b0}}, IS_IO};
  assign base   = bar_q;

  AST_BAR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bar_q));  // R6
  AST_BAR_LOWZ: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((bar_q & ~ADDR_MASK) == '0));  // R6
endmodule

// File: rtl/cfghdr_cmdsts.sv
module cfghdr_cmdsts
  import cfghdr_pkg::*;
#(
  parameter bit CAP_ON = 1'b1,
  parameter bit FAST66 = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [BE_W-1:0] be,
  input  logic [DW-1:0]   wdata,
  input  logic [5:0]      err_evt,
  output logic [15:0]     cmd_q,
  output logic [15:0]     sts_rd
);
  localparam logic [15:0] STS_RO = 16'h0200 | (CAP_ON ? 16'h0010 : 16'h0000)
                                            | (FAST66 ? 16'h0020 : 16'h0000);

  logic [15:0] sts_q;
  logic [15:0] evt16;
  logic [15:0] clr16;
  logic [DW-1:0] cmd_merged;

  assign evt16 = {err_evt[5:1], 2'b00, err_evt[0], 8'h00};
  assign clr16 = wr_en ? (wdata[31:16] & {{8{be[3]}}, {8{be[2]}}} & STS_W1C_MASK)
                       : 16'h0000;
  assign cmd_merged = be_merge({16'h0000, cmd_q}, wdata, be);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      sts_q <= '0;
    end else begin
      if (wr_en) cmd_q <= cmd_merged[15:0] & CMD_RW_MASK;
      sts_q <= ((sts_q & ~clr16) | evt16) & STS_W1C_MASK;
    end
  end

  assign sts_rd = sts_q | STS_RO;

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (err_evt != 6'd0) |=> ((sts_q & $past(evt16)) == $past(evt16)));  // R5
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cmd_q));  // R4
  AST_STS_NOCLR: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((sts_q & $past(sts_q)) == $past(sts_q)));  // R5
endmodule

// File: rtl/cfghdr_misc.sv
module cfghdr_misc (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_timing,
  input  logic        wr_irq,
  input  logic [1:0]  be,
  input  logic [15:0] wd,
  output logic [7:0]  line_size,
  output logic [7:0]  lat_timer,
  output logic [7:0]  irq_line
);
  always_ff @(posedge clk) begin
    if (rst) begin
      line_size <= '0;
      lat_timer <= '0;
      irq_line  <= '0;
    end else begin
      if (wr_timing && be[0]) line_size <= wd[7:0];
      if (wr_timing && be[1]) lat_timer <= wd[15:8];
      if (wr_irq && be[0])    irq_line  <= wd[7:0];
    end
  end

  AST_MISC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_timing || wr_irq) |=> $stable({line_size, lat_timer, irq_line}));  // R8
endmodule

// File: rtl/cfghdr_regs.sv
module cfghdr_regs
  import cfghdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
  parameter logic [7:0]  REV_ID     = 8'h01,
  parameter logic [23:0] CLASS_CODE = 24'h058000,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter logic [15:0] SUBSYS_VID = 16'h1A2B,
  parameter logic [15:0] SUBSYS_ID  = 16'h0001,
  parameter logic [7:0]  CAP_PTR    = 8'h00,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h00,
  parameter logic [7:0]  MAX_LAT    = 8'h00,
  parameter bit          FAST66     = 1'b0,
  parameter int          NUM_BARS   = 2,
  parameter logic [MAX_BARS-1:0]      BAR_IO = 3'b000,
  parameter logic [MAX_BARS*SZ_W-1:0] BAR_SZ = {5'd4, 5'd16, 5'd12}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   acc_valid,
  input  logic                   acc_write,
  input  logic [IDX_W-1:0]       acc_index,
  input  logic [BE_W-1:0]        acc_be,
  input  logic [DW-1:0]          acc_wdata,
  input  logic [5:0]             err_evt,
  input  logic [DW-1:0]          ext_rdata,
  output logic                   rd_valid,
  output logic [DW-1:0]          rd_data,
  output logic                   ext_sel,
  output logic                   ext_wr,
  output logic                   cmd_io_en,
  output logic                   cmd_mem_en,
  output logic                   cmd_bus_master,
  output logic                   cmd_perr_resp,
  output logic                   cmd_serr_en,
  output logic                   cmd_int_dis,
  output logic [MAX_BARS*DW-1:0] bar_base
);
  logic          in_hdr;
  logic          hdr_wr;
  logic [3:0]    slot;
  logic [15:0]   cmd_q;
  logic [15:0]   sts_rd;
  logic [7:0]    line_size, lat_timer, irq_line;
  logic [DW-1:0] bar_rd [MAX_BARS];
  logic [DW-1:0] hdr_rd;

  assign in_hdr  = (acc_index < IDX_W'(EXT_FIRST));
  assign slot    = acc_index[3:0];
  assign hdr_wr  = acc_valid && acc_write && in_hdr;
  assign ext_sel = acc_valid && !in_hdr;
  assign ext_wr  = ext_sel && acc_write;

  cfghdr_cmdsts #(.CAP_ON(CAP_PTR != 8'h00), .FAST66(FAST66)) u_cmdsts (
    .clk(clk), .rst(rst), .wr_en(hdr_wr && slot == 4'd1), .be(acc_be),
    .wdata(acc_wdata), .err_evt(err_evt), .cmd_q(cmd_q), .sts_rd(sts_rd)
  );

  cfghdr_misc u_misc (
    .clk(clk), .rst(rst),
    .wr_timing(hdr_wr && slot == 4'd3), .wr_irq(hdr_wr && slot == 4'd15),
    .be(acc_be[1:0]), .wd(acc_wdata[15:0]),
    .line_size(line_size), .lat_timer(lat_timer), .irq_line(irq_line)
  );

  for (genvar g = 0; g < MAX_BARS; g++) begin : g_bar
    if (g < NUM_BARS) begin : g_on
      cfghdr_bar #(.IS_IO(BAR_IO[g]), .SZ_LOG2(int'(BAR_SZ[g*SZ_W +: SZ_W]))) u_bar (
        .clk(clk), .rst(rst),
        .wr_en(hdr_wr && slot == 4'(BAR_FIRST + g)),
        .be(acc_be), .wdata(acc_wdata),
        .rd_val(bar_rd[g]), .base(bar_base[g*DW +: DW])
      );
    end else begin : g_off
      assign bar_rd[g]           = '0;
      assign bar_base[g*DW +: DW] = '0;
    end
  end

  always_comb begin
    hdr_rd = '0;
    case (slot)
      4'd0:  hdr_rd = {DEVICE_ID, VENDOR_ID};
      4'd1:  hdr_rd = {sts_rd, cmd_q};
      4'd2:  hdr_rd = {CLASS_CODE, REV_ID};
      4'd3:  hdr_rd = {8'h00, HDR_TYPE, lat_timer, line_size};
      4'd4:  hdr_rd = bar_rd[0];
      4'd5:  hdr_rd = bar_rd[1];
      4'd6:  hdr_rd = bar_rd[2];
      4'd11: hdr_rd = {SUBSYS_ID, SUBSYS_VID};
      4'd13: hdr_rd = {24'h000000, CAP_PTR};
      4'd15: hdr_rd = {MAX_LAT, MIN_GNT, INT_PIN, irq_line};
      default: hdr_rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rd_data <= in_hdr ? hdr_rd : ext_rdata;
    end
  end

  assign cmd_io_en      = cmd_q[0];
  assign cmd_mem_en     = cmd_q[1];
  assign cmd_bus_master = cmd_q[2];
  assign cmd_perr_resp  = cmd_q[6];
  assign cmd_serr_en    = cmd_q[8];
  assign cmd_int_dis    = cmd_q[10];

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> rd_valid);  // R3
  AST_NO_STRAY_RDV: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && !acc_write) |=> !rd_valid);  // R3
  AST_EXT_RDATA: assert property (@(posedge clk) disable iff (rst)
    (ext_sel && !acc_write) |=> (rd_data == $past(ext_rdata)));  // R9
  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (!rd_valid && !cmd_io_en && !cmd_mem_en && bar_base == '0));  // R10
endmodule

// File: tb/cfghdr_regs_test.sv
module cfghdr_regs_test;
  localparam logic [15:0] VID = 16'h10EE, DID = 16'h7E21, SVID = 16'h5A5A, SID = 16'hC3C3;
  localparam logic [7:0]  REV = 8'h2C, CAPP = 8'h40, IPIN = 8'h01, MGNT = 8'h08, MLAT = 8'h10;
  localparam logic [23:0] CLS = 24'h118000;
  localparam logic [2:0]  IO_SEL = 3'b010;
  localparam int SZ0 = 12, SZ1 = 4, SZ2 = 31;

  logic clk = 1'b0, rst = 1'b1;
  logic acc_valid = 0, acc_write = 0;
  logic [5:0] acc_index = 0;
  logic [3:0] acc_be = 0;
  logic [31:0] acc_wdata = 0;
  logic [5:0] err_evt = 0;
  logic [31:0] ext_rdata;
  logic rd_valid, ext_sel, ext_wr;
  logic [31:0] rd_data;
  logic c_io, c_mem, c_bm, c_pe, c_se, c_id;
  logic [95:0] bar_base;

  int n_chk = 0, n_bad = 0;
  logic [15:0] cmd_m, sts_m;
  logic [7:0]  cls_m, lat_m, il_m;
  logic [31:0] bar_m [3];

  assign ext_rdata = 32'hCAFE_0000 | {26'd0, acc_index};
  always #5 clk = ~clk;

  cfghdr_regs #(
    .VENDOR_ID(VID), .DEVICE_ID(DID), .REV_ID(REV), .CLASS_CODE(CLS), .HDR_TYPE(8'h00),
    .SUBSYS_VID(SVID), .SUBSYS_ID(SID), .CAP_PTR(CAPP), .INT_PIN(IPIN), .MIN_GNT(MGNT),
    .MAX_LAT(MLAT), .FAST66(1'b1), .NUM_BARS(3), .BAR_IO(IO_SEL),
    .BAR_SZ({5'd31, 5'd4, 5'd12})
  ) uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_index(acc_index), .acc_be(acc_be), .acc_wdata(acc_wdata), .err_evt(err_evt),
    .ext_rdata(ext_rdata), .rd_valid(rd_valid), .rd_data(rd_data), .ext_sel(ext_sel),
    .ext_wr(ext_wr), .cmd_io_en(c_io), .cmd_mem_en(c_mem), .cmd_bus_master(c_bm),
    .cmd_perr_resp(c_pe), .cmd_serr_en(c_se), .cmd_int_dis(c_id), .bar_base(bar_base)
  );

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bar_mask(input int i);
    int s;
    s = (i == 0) ? SZ0 : (i == 1) ? SZ1 : SZ2;
    return 32'hFFFF_FFFF << s;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r;
    r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [5:0] idx);
    if (idx >= 6'd16) return 32'hCAFE_0000 | {26'd0, idx};
    case (idx[3:0])
      4'd0:  return {DID, VID};
      4'd1:  return {sts_m | 16'h0230, cmd_m};
      4'd2:  return {CLS, REV};
      4'd3:  return {16'h0000, lat_m, cls_m};
      4'd4:  return bar_m[0];
      4'd5:  return bar_m[1] | 32'd1;
      4'd6:  return bar_m[2];
      4'd11: return {SID, SVID};
      4'd13: return {24'd0, CAPP};
      4'd15: return {MLAT, MGNT, IPIN, il_m};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [5:0] idx);
    if (idx >= 6'd16) return "R9";
    case (idx[3:0])
      4'd0, 4'd2, 4'd11, 4'd13: return "R1";
      4'd1: return "R5";
      4'd3, 4'd15: return "R8";
      4'd4, 4'd6: return "R6";
      4'd5: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic model_reset();
    cmd_m = 0; sts_m = 0; cls_m = 0; lat_m = 0; il_m = 0;
    for (int i = 0; i < 3; i++) bar_m[i] = 0;
  endtask

  task automatic model_step(input bit wr, input logic [5:0] idx, input logic [3:0] be,
                            input logic [31:0] wd, input logic [5:0] evt);
    logic [15:0] clr, e16;
    clr = 0;
    e16 = {evt[5:1], 2'b00, evt[0], 8'h00};
    if (wr && idx < 6'd16) begin
      case (idx[3:0])
        4'd1: begin
          cmd_m = merge({16'h0, cmd_m}, wd, be) & 32'h0547;
          clr = wd[31:16] & {{8{be[3]}}, {8{be[2]}}} & 16'hF900;
        end
        4'd3: begin
          if (be[0]) cls_m = wd[7:0];
          if (be[1]) lat_m = wd[15:8];
        end
        4'd4, 4'd5, 4'd6: bar_m[idx - 4] = merge(bar_m[idx - 4], wd, be) & bar_mask(idx - 4);
        4'd15: if (be[0]) il_m = wd[7:0];
        default: ;
      endcase
    end
    sts_m = (sts_m & ~clr) | e16;
  endtask

  task automatic op(input bit wr, input logic [5:0] idx, input logic [3:0] be,
                    input logic [31:0] wd, input logic [5:0] evt);
    logic [31:0] exp;
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_index = idx; acc_be = be; acc_wdata = wd; err_evt = evt;
    #1;
    check("R9 ext_sel", {94'd0, ext_sel, ext_wr}, {94'd0, idx >= 6'd16, wr && idx >= 6'd16});
    exp = exp_read(idx);
    @(posedge clk);
    model_step(wr, idx, be, wd, evt);
    @(negedge clk);
    check("R3 rd_valid", {95'd0, rd_valid}, {95'd0, !wr});
    if (!wr) check(req_of(idx), {64'd0, rd_data}, {64'd0, exp});
    check("R4 cmd outputs", {90'd0, c_io, c_mem, c_bm, c_pe, c_se, c_id},
          {90'd0, cmd_m[0], cmd_m[1], cmd_m[2], cmd_m[6], cmd_m[8], cmd_m[10]});
    check("R11 bar_base", bar_base, {bar_m[2], bar_m[1], bar_m[0]});
    acc_valid = 0; acc_write = 0; err_evt = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
    check("R10 rd_valid after reset", {95'd0, rd_valid}, 96'd0);
    for (int i = 0; i < 16; i++) op(0, 6'(i), 4'hF, 0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();                                        // R10 reset values
    // R1: writes to read-only identification dwords
    op(1, 6'd0, 4'hF, 32'hFFFF_FFFF, 0);  op(0, 6'd0, 4'hF, 0, 0);
    op(1, 6'd13, 4'hF, 32'h0, 0);         op(0, 6'd13, 4'hF, 0, 0);
    // R6/R7 sizing writes
    for (int i = 4; i < 7; i++) begin
      op(1, 6'(i), 4'hF, 32'hFFFF_FFFF, 0); op(0, 6'(i), 4'hF, 0, 0);
    end
    // R8 partial BAR and field writes
    op(1, 6'd6, 4'b0111, 32'h0000_0000, 0); op(0, 6'd6, 4'hF, 0, 0);
    op(1, 6'd4, 4'b0010, 32'h0000_AB00, 0); op(0, 6'd4, 4'hF, 0, 0);
    op(1, 6'd3, 4'b0010, 32'h1234_5678, 0); op(0, 6'd3, 4'hF, 0, 0);
    op(1, 6'd15, 4'b1110, 32'hFFFF_FF00, 0); op(0, 6'd15, 4'hF, 0, 0);
    // R4 command mask
    op(1, 6'd1, 4'b0011, 32'h0000_FFFF, 0); op(0, 6'd1, 4'hF, 0, 0);
    // R5 events, W1C, zero write, collision
    op(0, 6'd1, 4'hF, 0, 6'h3F);  op(0, 6'd1, 4'hF, 0, 0);
    op(1, 6'd1, 4'b1100, 32'h0000_0000, 0); op(0, 6'd1, 4'hF, 0, 0);
    op(1, 6'd1, 4'b1100, 32'h4100_0000, 0); op(0, 6'd1, 4'hF, 0, 0);
    op(1, 6'd1, 4'b1000, 32'hF800_0000, 6'h02); op(0, 6'd1, 4'hF, 0, 0);
    // R2 unimplemented and R9 extension
    op(1, 6'd7, 4'hF, 32'hFFFF_FFFF, 0); op(0, 6'd7, 4'hF, 0, 0);
    op(1, 6'd40, 4'hF, 32'hFFFF_FFFF, 0); op(0, 6'd20, 4'hF, 0, 0);
    for (int i = 0; i < 16; i++) op(0, 6'(i), 4'hF, 0, 0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [5:0] idx;
      idx = ($urandom % 4 == 0) ? 6'($urandom % 64) : 6'($urandom % 16);
      op(1'($urandom % 2), idx, 4'($urandom), $urandom,
         ($urandom % 6 == 0) ? 6'($urandom) : 6'd0);
    end
    do_reset();                                        // R10 reset mid-run
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule